// File: doc/BRIEF.md
# Bus Cycle Timer with Set/Clear Control Flags

This block keeps the isochronous cycle time of a serial-bus link layer and holds the flags that control it. A host changes the flags through a single write port with a select line. With the select low, every 1 in the write data turns the matching flag on. With the select high, every 1 turns the matching flag off. A 0 in the write data never changes a flag. The read port always shows the current flags.

The timer has three fields: a 12-bit offset, a 13-bit cycle number and a 7-bit seconds field. By default the offset wraps every 3072 ticks of the timer clock, which is 125 µs at 24.576 MHz. A source-select flag can hand the wrap over to an external strobe, which passes through a two-flop synchronizer first. If the node is cycle master and the physical layer reports it as bus root, each wrap raises a one-cycle cycle-start request. In external mode, a missing strobe makes the timer stall at its last offset and raises a cycle-too-long event. That event clears the master flag and keeps it cleared until the host acknowledges the event.

Top module: `bus_cycle_ctl`

## Requirements
- R1: A write with `reg_wr_clr`=0 sets each writable flag whose data bit is 1, and leaves every other flag unchanged. The writable flags are bits 22 (external source), 21 (cycle master), 20 (timer run), 10 (accept PHY packets), 9 (accept self-ID) and 6 (filter lock). All other bits of `reg_rd_data` read 0.
- R2: A write with `reg_wr_clr`=1 clears each of bits 22, 21, 20, 10 and 9 whose data bit is 1. It never clears bit 6.
- R3: Bit 6 drives `sync_filter_force`. Only reset returns it to 0.
- R4: `rx_phy_pkt_en` follows bit 10 and `rx_self_id_en` follows bit 9.
- R5: While bit 20 is 0, `cyc_offset` holds its value.
- R6: With bit 20 at 1 and bit 22 at 0, the offset counts up by one per clock from 0 to 3071. It then returns to 0, and on that same clock `cyc_count` goes up by one.
- R7: `cyc_count` wraps from 7999 to 0. That wrap adds one to `cyc_seconds`.
- R8: With bits 22 and 20 set, a rising edge on `cyc_in_async` forces a wrap (offset 0, count +1) on the third clock edge after the input is first sampled high, whatever the offset value is.
- R9: In external mode, when the offset reaches 3071 before any strobe arrives, `too_long_evt` pulses for one cycle and the offset stays at 3071 until a strobe comes.
- R10: `too_long_flag` goes to 1 on the clock after the event pulse. It stays at 1 until a `too_long_clr` pulse.
- R11: The event pulse clears bit 21 on the next clock. While `too_long_flag` is 1, a write that sets bit 21 has no effect.
- R12: `cycle_start_req` goes high for the one cycle after each wrap, but only if bit 21 was 1 and `phy_is_root` was 1 at that wrap. At any other time it stays low.
- R13: After reset, all flags, counters and pulse outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Flag write strobe |
| reg_wr_clr | input | 1 | 0 selects the set address, 1 selects the clear address |
| reg_wr_data | input | 32 | Write mask |
| reg_rd_data | output | 32 | Current flag values |
| cyc_in_async | input | 1 | External cycle strobe, asynchronous |
| phy_is_root | input | 1 | Physical layer reports this node as root |
| too_long_clr | input | 1 | Clears the sticky cycle-too-long flag |
| rx_phy_pkt_en | output | 1 | Accept PHY packets |
| rx_self_id_en | output | 1 | Accept self-ID packets |
| sync_filter_force | output | 1 | Forces every context's sync filter on |
| cycle_start_req | output | 1 | One-cycle cycle-start request |
| too_long_evt | output | 1 | One-cycle cycle-too-long event |
| too_long_flag | output | 1 | Sticky cycle-too-long flag |
| cyc_offset | output | 12 | Tick offset within the cycle |
| cyc_count | output | 13 | Cycle number within the second |
| cyc_seconds | output | 7 | Seconds count |

## Verification
On every cycle, the assertions check four things. The offset and cycle number stay inside their ranges. A stopped timer holds still. The event and request outputs are single-cycle pulses, and a request only appears after the root input was high. The lock bit and the sticky flag only fall as the requirements allow, and each event clears the master flag. Other behaviour needs the bench's scenarios to show it. This covers the exact 3072-tick wrap, the three-edge latency of the external strobe, the stall at 3071 and its release, the carry into seconds after 8000 wraps, and the rule that a master set is ignored while the event is still unacknowledged.

// File: rtl/bct_pkg.sv
// Package: bit positions and masks of the cycle-timer control flags.
// Assumes a 32-bit host data path. Positions are visible to software.
package bct_pkg;
    localparam int REG_W       = 32;
    localparam int B_EXT_SRC   = 22;
    localparam int B_MASTER    = 21;
    localparam int B_RUN       = 20;
    localparam int B_RX_PHY    = 10;
    localparam int B_RX_SELFID = 9;
    localparam int B_LOCK      = 6;

    localparam logic [REG_W-1:0] SET_MASK =
        (32'd1 << B_EXT_SRC) | (32'd1 << B_MASTER) | (32'd1 << B_RUN) |
        (32'd1 << B_RX_PHY)  | (32'd1 << B_RX_SELFID) | (32'd1 << B_LOCK);
    // The lock bit is set-only, so the clear mask leaves it out.
    localparam logic [REG_W-1:0] CLR_MASK = SET_MASK & ~(32'd1 << B_LOCK);
endpackage

// File: rtl/bct_ctrl_reg.sv
// Control flag register with set and clear write paths, plus the
// sticky cycle-too-long flag. An event pulse clears the master flag.
// Setting the master flag is refused while the sticky flag is 1.
// Assumes wr_en is a single-cycle strobe in the clk domain.
module bct_ctrl_reg
    import bct_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_clr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             evt,
    input  logic             evt_clr,
    output logic [REG_W-1:0] flags,
    output logic             evt_flag
);
    logic [REG_W-1:0] flags_nxt;
    logic [REG_W-1:0] set_allow;

    // Purpose: refuse a master set while the event is unacknowledged.
    always_comb begin
        set_allow = SET_MASK;
        if (evt_flag) set_allow[B_MASTER] = 1'b0;
    end

    // Purpose: compute the next flag value from the write and the event.
    always_comb begin
        flags_nxt = flags;
        if (wr_en) begin
            if (wr_clr) flags_nxt = flags & ~(wr_data & CLR_MASK);
            else        flags_nxt = flags | (wr_data & set_allow);
        end
        if (evt) flags_nxt[B_MASTER] = 1'b0;
    end

    // Purpose: flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= flags_nxt;
    end

    // Purpose: sticky event flag. A new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       evt_flag <= 1'b0;
        else if (evt)     evt_flag <= 1'b1;
        else if (evt_clr) evt_flag <= 1'b0;
    end
endmodule

// File: rtl/bct_edge_sync.sv
// Synchronizer chain with rising-edge detection for an asynchronous strobe.
// Assumes the strobe stays high for at least one clk period.
module bct_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Purpose: synchronizer shift chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
    end

    // Purpose: delayed copy of the synchronized output for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/bct_timer.sv
// Cycle timer: offset, cycle number and seconds fields. It wraps on an
// internal count or on an external edge. It stalls at the last offset in
// external mode and pulses an event when it gets there. It also issues a
// gated cycle-start request on each wrap.
module bct_timer #(
    parameter int TICKS_PER_CYC = 3072,
    parameter int CYC_PER_SEC   = 8000,
    parameter int OFF_W         = 12,
    parameter int CNT_W         = 13,
    parameter int SEC_W         = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ext_sel,
    input  logic             ext_rise,
    input  logic             start_gate,
    output logic [OFF_W-1:0] offset,
    output logic [CNT_W-1:0] count,
    output logic [SEC_W-1:0] seconds,
    output logic             start_req,
    output logic             late_evt
);
    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(TICKS_PER_CYC - 1);
    localparam logic [OFF_W-1:0] OFF_PRE  = OFF_W'(TICKS_PER_CYC - 2);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYC_PER_SEC - 1);

    logic wrap;
    logic stall;

    assign wrap  = run && (ext_sel ? ext_rise : (offset == OFF_LAST));
    assign stall = ext_sel && (offset == OFF_LAST);

    // Purpose: offset counter.
    always_ff @(posedge clk) begin
        if (!rst_n)              offset <= '0;
        else if (wrap)           offset <= '0;
        else if (run && !stall)  offset <= offset + 1'b1;
    end

    // Purpose: cycle number and seconds, advanced on each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            seconds <= '0;
        end else if (wrap) begin
            if (count == CNT_LAST) begin
                count   <= '0;
                seconds <= seconds + 1'b1;
            end else begin
                count   <= count + 1'b1;
            end
        end
    end

    // Purpose: registered cycle-start request and late-strobe event pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_req <= 1'b0;
            late_evt  <= 1'b0;
        end else begin
            start_req <= wrap && start_gate;
            late_evt  <= run && ext_sel && !ext_rise && (offset == OFF_PRE);
        end
    end
endmodule

// File: rtl/bus_cycle_ctl.sv
// Top level: control flags, external strobe synchronizer and cycle timer.
// Assumes every input except cyc_in_async is synchronous to clk.
module bus_cycle_ctl
    import bct_pkg::*;
#(
    parameter int TICKS_PER_CYC = 3072,
    parameter int CYC_PER_SEC   = 8000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic        reg_wr_clr,
    input  logic [31:0] reg_wr_data,
    output logic [31:0] reg_rd_data,
    input  logic        cyc_in_async,
    input  logic        phy_is_root,
    input  logic        too_long_clr,
    output logic        rx_phy_pkt_en,
    output logic        rx_self_id_en,
    output logic        sync_filter_force,
    output logic        cycle_start_req,
    output logic        too_long_evt,
    output logic        too_long_flag,
    output logic [11:0] cyc_offset,
    output logic [12:0] cyc_count,
    output logic [6:0]  cyc_seconds
);
    logic [REG_W-1:0] flags;
    logic             ext_rise;

    bct_ctrl_reg u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_clr   (reg_wr_clr),
        .wr_data  (reg_wr_data),
        .evt      (too_long_evt),
        .evt_clr  (too_long_clr),
        .flags    (flags),
        .evt_flag (too_long_flag)
    );

    bct_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cyc_in_async),
        .rise  (ext_rise)
    );

    bct_timer #(
        .TICKS_PER_CYC (TICKS_PER_CYC),
        .CYC_PER_SEC   (CYC_PER_SEC),
        .OFF_W         (12),
        .CNT_W         (13),
        .SEC_W         (7)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (flags[B_RUN]),
        .ext_sel    (flags[B_EXT_SRC]),
        .ext_rise   (ext_rise),
        .start_gate (flags[B_MASTER] && phy_is_root),
        .offset     (cyc_offset),
        .count      (cyc_count),
        .seconds    (cyc_seconds),
        .start_req  (cycle_start_req),
        .late_evt   (too_long_evt)
    );

    assign reg_rd_data       = flags;
    assign rx_phy_pkt_en     = flags[B_RX_PHY];
    assign rx_self_id_en     = flags[B_RX_SELFID];
    assign sync_filter_force = flags[B_LOCK];
endmodule

// File: rtl/bus_cycle_ctl_chk.sv
// Checker for bus_cycle_ctl. It watches only the top-level ports, and it
// is attached to every instance by the bind statement below.
module bus_cycle_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] reg_rd_data,
    input logic        phy_is_root,
    input logic        too_long_clr,
    input logic        cycle_start_req,
    input logic        too_long_evt,
    input logic        too_long_flag,
    input logic [11:0] cyc_offset,
    input logic [12:0] cyc_count
);
    // R6 / R7: counters stay inside their ranges.
    a_r6_offset_range: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_offset < 12'd3072);
    a_r7_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_count < 13'd8000);
    // R5: a stopped timer holds its offset.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_data[20] |=> $stable(cyc_offset));
    // R9: the event is a single-cycle pulse.
    a_r9_evt_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        too_long_evt |=> !too_long_evt);
    // R10: the sticky flag only falls on a clear strobe.
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (too_long_flag && !too_long_clr) |=> too_long_flag);
    // R11: the event clears the master flag.
    a_r11_master_off: assert property (@(posedge clk) disable iff (!rst_n)
        too_long_evt |=> !reg_rd_data[21]);
    // R3: the lock bit never falls outside reset.
    a_r3_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_data[6] |=> reg_rd_data[6]);
    // R12: the request is one cycle wide and needs the root input.
    a_r12_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start_req |=> !cycle_start_req);
    a_r12_req_root: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start_req |-> $past(phy_is_root));
endmodule

bind bus_cycle_ctl bus_cycle_ctl_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .reg_rd_data     (reg_rd_data),
    .phy_is_root     (phy_is_root),
    .too_long_clr    (too_long_clr),
    .cycle_start_req (cycle_start_req),
    .too_long_evt    (too_long_evt),
    .too_long_flag   (too_long_flag),
    .cyc_offset      (cyc_offset),
    .cyc_count       (cyc_count)
);

// File: tb/bus_cycle_ctl_tb.sv
module bus_cycle_ctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_wr_clr = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        cyc_in_async = 1'b0;
    logic        phy_is_root = 1'b0;
    logic        too_long_clr = 1'b0;
    logic        rx_phy_pkt_en, rx_self_id_en, sync_filter_force;
    logic        cycle_start_req, too_long_evt, too_long_flag;
    logic [11:0] cyc_offset;
    logic [12:0] cyc_count;
    logic [6:0]  cyc_seconds;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    bus_cycle_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_clr(reg_wr_clr),
        .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
        .cyc_in_async(cyc_in_async), .phy_is_root(phy_is_root),
        .too_long_clr(too_long_clr), .rx_phy_pkt_en(rx_phy_pkt_en),
        .rx_self_id_en(rx_self_id_en), .sync_filter_force(sync_filter_force),
        .cycle_start_req(cycle_start_req), .too_long_evt(too_long_evt),
        .too_long_flag(too_long_flag), .cyc_offset(cyc_offset),
        .cyc_count(cyc_count), .cyc_seconds(cyc_seconds)
    );

    // Vector: {clear select, write data, expected read value}
    typedef struct packed {
        logic        clr;
        logic [31:0] data;
        logic [31:0] expect_rd;
    } vec_t;
    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'hFFFF_FFFF, 32'h0070_0640},
        '{1'b1, 32'hFFFF_FFFF, 32'h0000_0040},
        '{1'b0, 32'h0000_0200, 32'h0000_0240},
        '{1'b1, 32'h0000_0040, 32'h0000_0240},
        '{1'b0, 32'h0010_0000, 32'h0010_0240},
        '{1'b1, 32'h0000_0200, 32'h0010_0040},
        '{1'b0, 32'h0000_0000, 32'h0010_0040},
        '{1'b1, 32'h0010_0000, 32'h0000_0040}
    };

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Inputs change and outputs are sampled on the falling edge.
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic clr, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_wr_clr = clr; reg_wr_data = d;
        tick(1);
        reg_wr_en = 1'b0; reg_wr_clr = 1'b0; reg_wr_data = '0;
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [11:0] held;
        int          reqs;
        do_reset();
        // R13: everything is 0 after reset.
        check(reg_rd_data == 0 && cyc_offset == 0 && cyc_count == 0 && cyc_seconds == 0
              && !cycle_start_req && !too_long_evt && !too_long_flag, "R13",
              reg_rd_data, 0);

        // R1 R2 R3 R4: set/clear vector table.
        for (int v = 0; v < NV; v++) begin
            wr(VECS[v].clr, VECS[v].data);
            check(reg_rd_data == VECS[v].expect_rd, "R1/R2", reg_rd_data, VECS[v].expect_rd);
            check({rx_phy_pkt_en, rx_self_id_en, sync_filter_force} ==
                  {VECS[v].expect_rd[10], VECS[v].expect_rd[9], VECS[v].expect_rd[6]},
                  "R3/R4", {rx_phy_pkt_en, rx_self_id_en, sync_filter_force},
                  {VECS[v].expect_rd[10], VECS[v].expect_rd[9], VECS[v].expect_rd[6]});
        end

        // R3: only reset clears the lock bit.
        do_reset();
        check(reg_rd_data[6] == 0 && !sync_filter_force, "R3", reg_rd_data, 0);

        // R5: a stopped timer holds; a running one counts.
        tick(10);
        check(cyc_offset == 0, "R5", cyc_offset, 0);
        wr(1'b0, 32'h0010_0000);
        tick(10);
        check(cyc_offset == 10, "R6", cyc_offset, 10);
        wr(1'b1, 32'h0010_0000);
        held = cyc_offset;
        tick(10);
        check(cyc_offset == held, "R5", cyc_offset, held);

        // R6 R12: internal wrap at 3072 with master and root set.
        do_reset();
        phy_is_root = 1'b1;
        wr(1'b0, 32'h0030_0000);
        tick(3071);
        check(cyc_offset == 3071 && cyc_count == 0, "R6", cyc_offset, 3071);
        check(!cycle_start_req, "R12", cycle_start_req, 0);
        tick(1);
        check(cyc_offset == 0 && cyc_count == 1, "R6", {cyc_count, cyc_offset}, {13'd1, 12'd0});
        check(cycle_start_req, "R12", cycle_start_req, 1);
        tick(1);
        check(!cycle_start_req, "R12", cycle_start_req, 0);
        // R12: no request while root is low.
        phy_is_root = 1'b0;
        reqs = 0;
        for (int i = 0; i < 3100; i++) begin
            tick(1);
            if (cycle_start_req) reqs++;
        end
        check(reqs == 0 && cyc_count == 2, "R12", reqs, 0);

        // R8: external strobe forces a wrap with three-edge latency.
        do_reset();
        wr(1'b0, 32'h0070_0000);
        tick(20);
        cyc_in_async = 1'b1;
        tick(2);
        check(cyc_count == 0, "R8", cyc_count, 0);
        tick(1);
        check(cyc_offset == 0 && cyc_count == 1, "R8", {cyc_count, cyc_offset}, {13'd1, 12'd0});
        cyc_in_async = 1'b0;

        // R9 R10 R11: missing strobe stalls the timer and raises the event.
        while (cyc_offset != 12'd3071) tick(1);
        check(too_long_evt, "R9", too_long_evt, 1);
        tick(1);
        check(!too_long_evt && too_long_flag, "R10", {too_long_evt, too_long_flag}, 2'b01);
        check(reg_rd_data[21] == 0, "R11", reg_rd_data[21], 0);
        tick(5);
        check(cyc_offset == 3071 && !too_long_evt, "R9", cyc_offset, 3071);
        wr(1'b0, 32'h0020_0000);
        check(reg_rd_data[21] == 0, "R11", reg_rd_data[21], 0);
        cyc_in_async = 1'b1;
        tick(3);
        check(cyc_offset == 0 && cyc_count == 2, "R8", {cyc_count, cyc_offset}, {13'd2, 12'd0});
        cyc_in_async = 1'b0;
        check(too_long_flag, "R10", too_long_flag, 1);
        too_long_clr = 1'b1;
        tick(1);
        too_long_clr = 1'b0;
        check(!too_long_flag, "R10", too_long_flag, 0);
        wr(1'b0, 32'h0020_0000);
        check(reg_rd_data[21] == 1, "R11", reg_rd_data[21], 1);

        // R7: 8000 external wraps carry into seconds.
        do_reset();
        wr(1'b0, 32'h0050_0000);
        for (int i = 0; i < 8000; i++) begin
            cyc_in_async = 1'b1;
            tick(1);
            cyc_in_async = 1'b0;
            tick(1);
        end
        tick(4);
        check(cyc_count == 0 && cyc_seconds == 1, "R7", {cyc_seconds, cyc_count},
              {7'd1, 13'd0});

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule